// File: doc/BRIEF.md
# Paddle Position Line Counters

This block turns four analog paddle or joystick positions into 8-bit numbers. Each position sets the charge rate of a timing capacitor. An external comparator reports, as one digital flag per channel, whether that capacitor has charged past a fixed threshold. Software writes a start strobe, typically at the top of a video frame. The block then holds all capacitors discharged for a short settle interval measured in scan lines. After that it lets them charge and counts scan lines on each channel until that channel's comparator trips.

Each count freezes at the line where its capacitor crossed threshold. It stays frozen until the next start strobe. Software reads the results during the following blanking period. Two 16-bit read ports each pack the vertical and horizontal counts of one controller port. A count never saturates: the settle interval is chosen so that a full frame cannot push a count past 255. A count that is driven past 255 anyway wraps to zero.

Top module: `paddle_pos_top`

## Requirements
- R1: A cycle with `start_i` high clears all four counts to 0 and raises `discharge_o`. Both are visible in the following cycle. `start_i` takes precedence over `line_i` in the same cycle.
- R2: `discharge_o` stays high until `SETTLE_LINES` (default 7) line strobes have been seen after the start strobe, and drops in the cycle after the last of them. No count changes while `discharge_o` is high.
- R3: In the charging phase, every `line_i` strobe adds one to each unfrozen channel whose synchronized comparator flag is 0. The new value appears in the cycle after the strobe. Counts never change on a cycle without `line_i` or `start_i`.
- R4: A line strobe that sees a channel's synchronized flag at 1 freezes that channel. Its count then holds even if the flag later returns to 0, until the next start strobe.
- R5: Counts are 8 bits wide, step by exactly one, and wrap from 255 to 0 with no saturation.
- R6: `above_i[i]` feeds channel i. `port0_o` = {channel 1 (vertical), channel 0 (horizontal)} with the vertical count in bits 15-8 and the horizontal count in bits 7-0. `port1_o` = {channel 3, channel 2} in the same layout.
- R7: A start strobe during discharge or charging restarts the whole sequence. The counts clear, the frozen flags clear, and a full settle interval is served again.
- R8: After reset the counts are 0 and `discharge_o` is low. Line strobes are ignored until the first start strobe.
- R9: Comparator flags pass through a two-flop synchronizer. A flag value reaches the counting logic two clock edges after it is sampled, so a flag that rises one cycle before a strobe does not yet stop that strobe's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe (register write), one cycle |
| line_i | input | 1 | One-cycle pulse per horizontal scan line |
| above_i | input | 4 | Asynchronous comparator flags, 1 = capacitor above threshold |
| discharge_o | output | 1 | High while capacitors are held discharged |
| port0_o | output | 16 | Controller port 0: vertical [15:8], horizontal [7:0] |
| port1_o | output | 16 | Controller port 1: vertical [15:8], horizontal [7:0] |

## Verification
The bench targets four corner cases.

- **Settle boundary.** The bench counts line strobes across the settle interval. A settle counter that is off by one would let the last discharge line be counted, or skip the first charging line, and every result would be one off.
- **Freeze.** After a channel freezes, the bench drops its comparator again. A design that gated counting with the live flag instead of a sticky freeze would resume counting at that point.
- **Wrap.** The bench runs a channel past 255. A saturating or widened counter would show 255 or a carry where 0 belongs.
- **Restart and late flags.** The bench issues a start strobe in the middle of charging, and raises a flag one cycle before a strobe. These catch a design that keeps stale counts, skips the second settle interval, or samples the comparator without the two synchronizer stages.

// File: rtl/paddle_pkg.sv
package paddle_pkg;
  localparam int N_CH = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CHARGE = 2'd2
  } phase_e;
endpackage

// File: rtl/paddle_sync.sv
module paddle_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/paddle_settle.sv
module paddle_settle
  import paddle_pkg::*;
#(
  parameter int SETTLE_LINES = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic line_i,
  output logic discharge_o,
  output logic charge_o
);
  localparam int LW = $clog2(SETTLE_LINES + 1);
  localparam logic [LW-1:0] LAST = LW'(SETTLE_LINES - 1);

  phase_e        phase_q;
  logic [LW-1:0] lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      lines_q <= '0;
    end else if (start_i) begin
      phase_q <= PH_SETTLE;
      lines_q <= '0;
    end else if (line_i && phase_q == PH_SETTLE) begin
      if (lines_q == LAST) begin
        phase_q <= PH_CHARGE;
        lines_q <= '0;
      end else begin
        lines_q <= lines_q + 1'b1;
      end
    end
  end

  assign discharge_o = (phase_q == PH_SETTLE);
  assign charge_o    = (phase_q == PH_CHARGE);
endmodule

// File: rtl/paddle_chan.sv
module paddle_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             above_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frozen_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
    end else if (step_i && !frozen_q) begin
      if (above_i) frozen_q <= 1'b1;
      else         cnt_q    <= cnt_q + 1'b1;  // free wrap
    end
  end

  assign cnt_o    = cnt_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/paddle_pos_top.sv
module paddle_pos_top
  import paddle_pkg::*;
#(
  parameter int SETTLE_LINES = 7,
  parameter int CNT_W        = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               line_i,
  input  logic [N_CH-1:0]    above_i,
  output logic               discharge_o,
  output logic [2*CNT_W-1:0] port0_o,
  output logic [2*CNT_W-1:0] port1_o
);
  logic [N_CH-1:0]  above_s;
  logic             charge;
  logic             step;
  logic [CNT_W-1:0] cnt [N_CH];
  logic [N_CH-1:0]  frozen_q;

  paddle_sync #(.W(N_CH), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (above_i),
    .q_o   (above_s)
  );

  paddle_settle #(.SETTLE_LINES(SETTLE_LINES)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .line_i     (line_i),
    .discharge_o(discharge_o),
    .charge_o   (charge)
  );

  assign step = line_i && charge;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    paddle_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_i),
      .step_i  (step),
      .above_i (above_s[g]),
      .cnt_o   (cnt[g]),
      .frozen_o(frozen_q[g])
    );
  end

  // even channel = horizontal (low byte), odd channel = vertical (high byte)
  assign port0_o = {cnt[1], cnt[0]};
  assign port1_o = {cnt[3], cnt[2]};
endmodule

// File: rtl/paddle_pos_chk.sv
module paddle_pos_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               line_i,
  input logic               discharge_o,
  input logic [2*CNT_W-1:0] port0_o,
  input logic [2*CNT_W-1:0] port1_o,
  input logic [3:0]         frozen_q
);
  logic [CNT_W-1:0] b [4];
  assign b[0] = port0_o[CNT_W-1:0];
  assign b[1] = port0_o[2*CNT_W-1:CNT_W];
  assign b[2] = port1_o[CNT_W-1:0];
  assign b[3] = port1_o[2*CNT_W-1:CNT_W];

  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (port0_o == '0 && port1_o == '0 && discharge_o));

  a_r2_hold_in_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discharge_o && !start_i) |=> ($stable(port0_o) && $stable(port1_o)));

  a_r3_no_line_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_i && !start_i) |=> ($stable(port0_o) && $stable(port1_o)));

  for (genvar g = 0; g < 4; g++) begin : g_a
    a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (b[g] == $past(b[g]) || b[g] == $past(b[g]) + 1'b1));

    a_r4_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frozen_q[g] && !start_i) |=> $stable(b[g]));
  end
endmodule

bind paddle_pos_top paddle_pos_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .line_i     (line_i),
  .discharge_o(discharge_o),
  .port0_o    (port0_o),
  .port1_o    (port1_o),
  .frozen_q   (frozen_q)
);

// File: tb/paddle_pos_top_tb_top.sv
module paddle_pos_top_tb_top;
  localparam int SETTLE   = 7;
  localparam int LINE_GAP = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_r = 1'b0;
  logic        line_r = 1'b0;
  logic [3:0]  above_r = '0;
  logic        discharge_o;
  logic [15:0] port0_o, port1_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int thr_q [4];

  always #4 clk_i = ~clk_i;  // 125 MHz

  paddle_pos_top dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_r),
    .line_i     (line_r),
    .above_i    (above_r),
    .discharge_o(discharge_o),
    .port0_o    (port0_o),
    .port1_o    (port1_o)
  );

  // behavioural reference model
  int         m_cnt [4];
  bit         m_frz [4];
  int         m_ph;      // 0 idle, 1 settle, 2 charge
  int         m_set;
  logic [3:0] a_hist [$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_frz[c] = 0; end
      m_ph = 0; m_set = 0;
      a_hist = '{4'b0, 4'b0};
    end else begin
      logic [3:0] seen;
      seen = a_hist.pop_front();
      a_hist.push_back(above_r);
      if (start_r) begin
        for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_frz[c] = 0; end
        m_ph = 1; m_set = 0;
      end else if (line_r) begin
        if (m_ph == 1) begin
          m_set++;
          if (m_set == SETTLE) m_ph = 2;
        end else if (m_ph == 2) begin
          for (int c = 0; c < 4; c++)
            if (!m_frz[c]) begin
              if (seen[c]) m_frz[c] = 1;
              else m_cnt[c] = (m_cnt[c] + 1) % 256;
            end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(discharge_o == (m_ph == 1), "R2 per-cycle discharge", int'(discharge_o), int'(m_ph == 1));
      chk(port0_o == {8'(m_cnt[1]), 8'(m_cnt[0])}, "R3/R6 per-cycle port0",
          int'(port0_o), int'({8'(m_cnt[1]), 8'(m_cnt[0])}));
      chk(port1_o == {8'(m_cnt[3]), 8'(m_cnt[2])}, "R3/R6 per-cycle port1",
          int'(port1_o), int'({8'(m_cnt[3]), 8'(m_cnt[2])}));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_start();
    start_r = 1'b1; tick(1); start_r = 1'b0; tick(3);
  endtask

  task automatic line_only();
    line_r = 1'b1; tick(1); line_r = 1'b0; tick(LINE_GAP - 1);
  endtask

  // count line k, then update comparators for the capacitor model
  task automatic line_k(int k);
    line_r = 1'b1; tick(1); line_r = 1'b0;
    for (int c = 0; c < 4; c++) above_r[c] = (k >= thr_q[c]);
    tick(LINE_GAP - 1);
  endtask

  task automatic settle_then_arm();
    above_r = '0;
    do_start();
    repeat (SETTLE) line_only();
    for (int c = 0; c < 4; c++) above_r[c] = (thr_q[c] == 0);
    tick(3);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R8 reset state and idle lines
    chk(port0_o == 0 && port1_o == 0, "R8 reset counts", int'(port0_o | port1_o), 0);
    chk(discharge_o == 0, "R8 reset discharge", int'(discharge_o), 0);
    repeat (3) line_only();
    chk(port0_o == 0 && port1_o == 0, "R8 idle lines ignored", int'(port0_o | port1_o), 0);

    // R2 settle window
    above_r = '0;
    do_start();
    chk(discharge_o == 1, "R1 discharge after start", int'(discharge_o), 1);
    repeat (SETTLE - 1) line_only();
    chk(discharge_o == 1, "R2 still settling", int'(discharge_o), 1);
    chk(port0_o == 0 && port1_o == 0, "R2 no count in settle", int'(port0_o | port1_o), 0);
    line_only();
    chk(discharge_o == 0, "R2 settle done", int'(discharge_o), 0);

    // R3 R6 main measurement
    thr_q = '{3, 10, 0, 20};
    settle_then_arm();
    for (int k = 1; k <= 25; k++) line_k(k);
    chk(port0_o == {8'd10, 8'd3}, "R3/R6 port0 counts", int'(port0_o), int'({8'd10, 8'd3}));
    chk(port1_o == {8'd20, 8'd0}, "R3/R6 port1 counts", int'(port1_o), int'({8'd20, 8'd0}));

    // R4 freeze survives comparator drop
    above_r = '0;
    tick(3);
    repeat (5) line_only();
    chk(port0_o == {8'd10, 8'd3}, "R4 frozen port0", int'(port0_o), int'({8'd10, 8'd3}));
    chk(port1_o == {8'd20, 8'd0}, "R4 frozen port1", int'(port1_o), int'({8'd20, 8'd0}));

    // R6 distinct channel mapping
    thr_q = '{1, 2, 4, 8};
    settle_then_arm();
    for (int k = 1; k <= 12; k++) line_k(k);
    chk(port0_o == 16'h0201, "R6 port0 mapping", int'(port0_o), 16'h0201);
    chk(port1_o == 16'h0804, "R6 port1 mapping", int'(port1_o), 16'h0804);

    // R7 restart mid measurement
    thr_q = '{100, 100, 100, 100};
    settle_then_arm();
    for (int k = 1; k <= 12; k++) line_k(k);
    chk(port0_o == 16'h0c0c, "R3 mid count", int'(port0_o), 16'h0c0c);
    do_start();
    chk(port0_o == 0 && port1_o == 0, "R1 start clears", int'(port0_o | port1_o), 0);
    chk(discharge_o == 1, "R7 restart settles", int'(discharge_o), 1);
    repeat (SETTLE - 1) line_only();
    chk(discharge_o == 1 && port0_o == 0, "R7 full settle again", int'(port0_o), 0);
    line_only();
    line_only();
    chk(port0_o == 16'h0101, "R7 counting resumes", int'(port0_o), 16'h0101);

    // R9 synchronizer latency: flag raised one cycle before strobe
    thr_q = '{100, 100, 100, 100};
    settle_then_arm();
    line_only(); line_only();
    above_r[1] = 1'b1;
    tick(1);
    line_only();
    chk(port0_o[15:8] == 8'd3, "R9 late flag not yet seen", int'(port0_o[15:8]), 3);
    line_only();
    chk(port0_o[15:8] == 8'd3, "R9 flag seen next line", int'(port0_o[15:8]), 3);
    chk(port0_o[7:0] == 8'd4, "R9 other channel counts", int'(port0_o[7:0]), 4);

    // R5 wrap
    thr_q = '{1000, 1000, 1000, 1000};
    settle_then_arm();
    for (int k = 1; k <= 260; k++) begin
      line_r = 1'b1; tick(1); line_r = 1'b0;
      if (k == 255) chk(port0_o[7:0] == 8'd255, "R5 reaches 255", int'(port0_o[7:0]), 255);
      if (k == 256) chk(port0_o[7:0] == 8'd0, "R5 wraps to 0", int'(port0_o[7:0]), 0);
      tick(LINE_GAP - 1);
    end
    chk(port1_o == 16'h0404, "R5 after wrap", int'(port1_o), 16'h0404);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule